// File: doc/BRIEF.md
# Dual Down-Counting Wake-Up Timers

This block holds two independent down-counters behind a small nibble-wide register bus. The short timer is 4 bits wide and steps once for each pulse on a slow tick strobe (nominally 16 Hz). The long timer is 32 bits wide and steps once for each pulse on a fast tick strobe (nominally 8192 Hz). Both strobes come from outside the block, already in its clock domain. A single run bit gates both timers, and that bit sits in the long timer's control nibble.

Each timer fires when it wraps from zero to all ones. Depending on that timer's two enable bits, the wrap produces a one-cycle wake-up pulse, a one-cycle non-maskable interrupt pulse, or both. It also sets sticky service-request flags that software reads and clears over the register bus. The bus is a plain register port and not a stream: a write takes effect on the clock edge where it is presented, and reads are combinational from the stored state. There is no back-pressure.

The control nibble has the same layout for both timers. Bit 0 is run, and it has effect only in the long timer's nibble. Bit 1 is the interrupt enable. Bit 2 is the wake enable. Bit 3 is the sticky service request.

Register offsets:
- 0: short counter.
- 1: short control.
- 2: long control.
- 3: global service nibble. Bit 2 is the timer service flag.
- 8 to 15: the long counter, one nibble per offset, least significant nibble at offset 8.

Top module: `wakeup_timer_pair`

## Requirements
- R1: After reset, both counters, both control nibbles and the global service nibble read 0, and wake_pulse and nmi_pulse are low.
- R2: While long-control bit 0 is 1, each tick_slow pulse lowers the short counter by one modulo 16. While that bit is 0, tick_slow leaves the short counter unchanged.
- R3: While long-control bit 0 is 1, each tick_fast pulse lowers the long counter by one modulo 2^32. While that bit is 0, tick_fast leaves the long counter unchanged.
- R4: A write to offset 8+k replaces only bits 4k+3..4k of the long counter, and reading offset 8+k returns those bits.
- R5: A bus write to a counter in the same cycle as that counter's tick stores the written value. The counter does not decrement that cycle and it does not count as a wrap.
- R6: When a counter wraps from 0 to all ones and that timer's control bit 2 is 1, wake_pulse is high for the one cycle after the ticking edge. The same event sets that timer's control bit 3 and bit 2 of the global service nibble.
- R7: When a counter wraps and that timer's control bit 1 is 1, nmi_pulse is high for the one cycle after the ticking edge. The same event sets the same two flags as in R6.
- R8: A wrap with both control bits 1 and 2 at 0 raises no pulse and sets no flag.
- R9: Service flags stay set until software writes a 0 to them. If a wrap sets a flag in the same cycle that software writes that nibble, the flag ends up set. The enables in force during a cycle are the ones stored before that cycle's write.
- R10: Offsets 4 to 7 and 16 to 31 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | One-cycle strobe that steps the short timer |
| tick_fast | input | 1 | One-cycle strobe that steps the long timer |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 4 | Write nibble |
| bus_rdata | output | 4 | Read nibble for bus_addr |
| wake_pulse | output | 1 | One-cycle wake-up request |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |

## Verification
Two functions of this block can land in the same cycle.

The first case is a tick arriving together with a bus write to the same counter. The bench provokes it by asserting the strobe and the write together, including at a count of zero with enables set. It then confirms that the written value is stored and that no pulse appears.

The second case is a wrap arriving together with a software write to the control or global nibble. The bench judges it by reading back a set service flag.

A random phase with zero-heavy data keeps both collisions frequent and compares every cycle against a bench model.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  // Control nibble layout, shared by both timers (bit 3 .. bit 0).
  typedef struct packed {
    logic sreq;     // sticky service request
    logic wake_en;  // wake pulse on wrap
    logic irq_en;   // NMI pulse on wrap
    logic run;      // global run, meaningful in the long timer's nibble
  } wkt_ctl_t;

  localparam int NIB_W = 4;
  localparam int SVC_TIMER_BIT = 2;
endpackage

// File: rtl/wkt_down_counter.sv
module wkt_down_counter #(
  parameter int NIBBLES = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step,
  input  logic [NIBBLES-1:0]            nib_we,
  input  logic [wkt_pkg::NIB_W-1:0]     wdata,
  output logic [NIBBLES*wkt_pkg::NIB_W-1:0] count,
  output logic                          wrap
);
  localparam int W = NIBBLES * wkt_pkg::NIB_W;

  logic [W-1:0] cnt_q, cnt_d;
  logic         any_we;

  assign any_we = |nib_we;
  assign wrap   = step && !any_we && (cnt_q == '0);
  assign count  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (any_we) begin
      for (int k = 0; k < NIBBLES; k++) begin
        if (nib_we[k]) cnt_d[k*wkt_pkg::NIB_W +: wkt_pkg::NIB_W] = wdata;
      end
    end else if (step) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !any_we) |=> $stable(cnt_q)); // R2

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_we && cnt_q != '0) |=> (cnt_q < $past(cnt_q))); // R3

  AST_WRAP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '1)); // R2

  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib_chk
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      nib_we[g] |=> (cnt_q[g*wkt_pkg::NIB_W +: wkt_pkg::NIB_W] == $past(wdata))); // R5
  end
endmodule

// File: rtl/wkt_service.sv
module wkt_service
  import wkt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_short_ctl,
  input  logic             we_long_ctl,
  input  logic             we_svc,
  input  logic [NIB_W-1:0] wdata,
  input  logic             short_wrap,
  input  logic             long_wrap,
  output wkt_ctl_t         short_ctl,
  output wkt_ctl_t         long_ctl,
  output logic [NIB_W-1:0] svc,
  output logic             run,
  output logic             wake_pulse,
  output logic             nmi_pulse
);
  wkt_ctl_t         s_ctl_q, s_ctl_d, l_ctl_q, l_ctl_d;
  logic [NIB_W-1:0] svc_q, svc_d;
  logic             wake_q, nmi_q;
  logic             s_wake, s_irq, l_wake, l_irq, s_hit, l_hit;

  assign s_wake = short_wrap && s_ctl_q.wake_en;
  assign s_irq  = short_wrap && s_ctl_q.irq_en;
  assign l_wake = long_wrap  && l_ctl_q.wake_en;
  assign l_irq  = long_wrap  && l_ctl_q.irq_en;
  assign s_hit  = s_wake || s_irq;
  assign l_hit  = l_wake || l_irq;

  always_comb begin
    s_ctl_d = we_short_ctl ? wkt_ctl_t'(wdata) : s_ctl_q;
    l_ctl_d = we_long_ctl  ? wkt_ctl_t'(wdata) : l_ctl_q;
    svc_d   = we_svc ? wdata : svc_q;
    if (s_hit) s_ctl_d.sreq = 1'b1;
    if (l_hit) l_ctl_d.sreq = 1'b1;
    if (s_hit || l_hit) svc_d[SVC_TIMER_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ctl_q <= '0;
      l_ctl_q <= '0;
      svc_q   <= '0;
      wake_q  <= 1'b0;
      nmi_q   <= 1'b0;
    end else begin
      s_ctl_q <= s_ctl_d;
      l_ctl_q <= l_ctl_d;
      svc_q   <= svc_d;
      wake_q  <= s_wake || l_wake;
      nmi_q   <= s_irq || l_irq;
    end
  end

  assign short_ctl  = s_ctl_q;
  assign long_ctl   = l_ctl_q;
  assign svc        = svc_q;
  assign run        = l_ctl_q.run;
  assign wake_pulse = wake_q;
  assign nmi_pulse  = nmi_q;

  AST_WAKE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> svc_q[SVC_TIMER_BIT]); // R6

  AST_NMI_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |-> svc_q[SVC_TIMER_BIT]); // R7

  AST_NO_CAUSE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_wrap || long_wrap) |=> (!wake_pulse && !nmi_pulse)); // R8

  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ctl_q.sreq && !we_short_ctl) |=> s_ctl_q.sreq); // R9

  AST_SVC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q[SVC_TIMER_BIT] && !we_svc) |=> svc_q[SVC_TIMER_BIT]); // R9
endmodule

// File: rtl/wkt_regbus.sv
module wkt_regbus
  import wkt_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int LONG_NIBBLES = 8,
  parameter int A_SHORT_CNT  = 0,
  parameter int A_SHORT_CTL  = 1,
  parameter int A_LONG_CTL   = 2,
  parameter int A_SVC        = 3,
  parameter int A_LONG_BASE  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  output logic                            we_short_cnt,
  output logic                            we_short_ctl,
  output logic                            we_long_ctl,
  output logic                            we_svc,
  output logic [LONG_NIBBLES-1:0]         we_long,
  input  logic [NIB_W-1:0]                short_cnt,
  input  wkt_ctl_t                        short_ctl,
  input  wkt_ctl_t                        long_ctl,
  input  logic [NIB_W-1:0]                svc,
  input  logic [LONG_NIBBLES*NIB_W-1:0]   long_cnt,
  output logic [NIB_W-1:0]                bus_rdata
);
  logic hit_short_cnt, hit_short_ctl, hit_long_ctl, hit_svc;
  logic [LONG_NIBBLES-1:0] hit_long;

  assign hit_short_cnt = (bus_addr == ADDR_W'(A_SHORT_CNT));
  assign hit_short_ctl = (bus_addr == ADDR_W'(A_SHORT_CTL));
  assign hit_long_ctl  = (bus_addr == ADDR_W'(A_LONG_CTL));
  assign hit_svc       = (bus_addr == ADDR_W'(A_SVC));

  for (genvar g = 0; g < LONG_NIBBLES; g++) begin : g_long_dec
    assign hit_long[g] = (bus_addr == ADDR_W'(A_LONG_BASE + g));
    assign we_long[g]  = bus_wr && hit_long[g];
  end

  assign we_short_cnt = bus_wr && hit_short_cnt;
  assign we_short_ctl = bus_wr && hit_short_ctl;
  assign we_long_ctl  = bus_wr && hit_long_ctl;
  assign we_svc       = bus_wr && hit_svc;

  always_comb begin
    bus_rdata = '0;
    if (hit_short_cnt) bus_rdata = short_cnt;
    if (hit_short_ctl) bus_rdata = short_ctl;
    if (hit_long_ctl)  bus_rdata = long_ctl;
    if (hit_svc)       bus_rdata = svc;
    for (int k = 0; k < LONG_NIBBLES; k++) begin
      if (hit_long[k]) bus_rdata = long_cnt[k*NIB_W +: NIB_W];
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_short_cnt, we_short_ctl, we_long_ctl, we_svc, we_long})); // R10
endmodule

// File: rtl/wakeup_timer_pair.sv
module wakeup_timer_pair
  import wkt_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int LONG_NIBBLES = 8,
  parameter int A_SHORT_CNT  = 0,
  parameter int A_SHORT_CTL  = 1,
  parameter int A_LONG_CTL   = 2,
  parameter int A_SVC        = 3,
  parameter int A_LONG_BASE  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_wdata,
  output logic [3:0]        bus_rdata,
  output logic              wake_pulse,
  output logic              nmi_pulse
);
  localparam int LONG_W = LONG_NIBBLES * NIB_W;

  logic                    we_short_cnt, we_short_ctl, we_long_ctl, we_svc;
  logic [LONG_NIBBLES-1:0] we_long;
  logic [NIB_W-1:0]        short_cnt, svc;
  logic [LONG_W-1:0]       long_cnt;
  wkt_ctl_t                short_ctl, long_ctl;
  logic                    run, short_wrap, long_wrap;

  wkt_regbus #(
    .ADDR_W(ADDR_W), .LONG_NIBBLES(LONG_NIBBLES),
    .A_SHORT_CNT(A_SHORT_CNT), .A_SHORT_CTL(A_SHORT_CTL),
    .A_LONG_CTL(A_LONG_CTL), .A_SVC(A_SVC), .A_LONG_BASE(A_LONG_BASE)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .we_short_cnt(we_short_cnt), .we_short_ctl(we_short_ctl),
    .we_long_ctl(we_long_ctl), .we_svc(we_svc), .we_long(we_long),
    .short_cnt(short_cnt), .short_ctl(short_ctl), .long_ctl(long_ctl),
    .svc(svc), .long_cnt(long_cnt), .bus_rdata(bus_rdata)
  );

  wkt_down_counter #(.NIBBLES(1)) u_short (
    .clk(clk), .rst_n(rst_n), .step(tick_slow && run),
    .nib_we(we_short_cnt), .wdata(bus_wdata),
    .count(short_cnt), .wrap(short_wrap)
  );

  wkt_down_counter #(.NIBBLES(LONG_NIBBLES)) u_long (
    .clk(clk), .rst_n(rst_n), .step(tick_fast && run),
    .nib_we(we_long), .wdata(bus_wdata),
    .count(long_cnt), .wrap(long_wrap)
  );

  wkt_service u_svc (
    .clk(clk), .rst_n(rst_n),
    .we_short_ctl(we_short_ctl), .we_long_ctl(we_long_ctl), .we_svc(we_svc),
    .wdata(bus_wdata), .short_wrap(short_wrap), .long_wrap(long_wrap),
    .short_ctl(short_ctl), .long_ctl(long_ctl), .svc(svc), .run(run),
    .wake_pulse(wake_pulse), .nmi_pulse(nmi_pulse)
  );

  AST_HALTED_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!short_wrap && !long_wrap)); // R2
endmodule

// File: tb/wakeup_timer_pair_test.sv
module wakeup_timer_pair_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_slow = 1'b0, tick_fast = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic       wake_pulse, nmi_pulse;

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R1";

  logic [3:0]  m_s, m_sc, m_lc, m_svc;
  logic [31:0] m_l;
  logic        m_wake, m_nmi;

  always #(CLK_PERIOD/2) clk = ~clk;

  wakeup_timer_pair uut (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wake_pulse(wake_pulse), .nmi_pulse(nmi_pulse)
  );

  function automatic logic [3:0] model_read(input logic [4:0] a);
    if (a == 5'd0) return m_s;
    if (a == 5'd1) return m_sc;
    if (a == 5'd2) return m_lc;
    if (a == 5'd3) return m_svc;
    if (a >= 5'd8 && a <= 5'd15) return m_l[(int'(a) - 8)*4 +: 4];
    return 4'h0;
  endfunction

  task automatic model_update(input logic wr, input logic [4:0] a, input logic [3:0] d,
                              input logic ts, input logic tf);
    logic run, s_we, l_we, s_wrap, l_wrap, sw, si, lw, li;
    logic [3:0] nsc, nlc, nsvc;
    run    = m_lc[0];
    s_we   = wr && a == 5'd0;
    l_we   = wr && a >= 5'd8 && a <= 5'd15;
    s_wrap = ts && run && !s_we && m_s == 4'h0;
    l_wrap = tf && run && !l_we && m_l == 32'h0;
    sw = s_wrap && m_sc[2]; si = s_wrap && m_sc[1];
    lw = l_wrap && m_lc[2]; li = l_wrap && m_lc[1];
    nsc  = (wr && a == 5'd1) ? d : m_sc;
    nlc  = (wr && a == 5'd2) ? d : m_lc;
    nsvc = (wr && a == 5'd3) ? d : m_svc;
    if (sw || si) nsc[3] = 1'b1;
    if (lw || li) nlc[3] = 1'b1;
    if (sw || si || lw || li) nsvc[2] = 1'b1;
    if (s_we) m_s = d; else if (ts && run) m_s = m_s - 4'd1;
    if (l_we) m_l[(int'(a) - 8)*4 +: 4] = d; else if (tf && run) m_l = m_l - 32'd1;
    m_sc = nsc; m_lc = nlc; m_svc = nsvc;
    m_wake = sw || lw;
    m_nmi  = si || li;
  endtask

  task automatic expect4(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock: drive at negedge, update model after the edge, compare at next negedge.
  task automatic cycle(input logic wr, input logic [4:0] a, input logic [3:0] d,
                       input logic ts, input logic tf);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick_slow = ts; tick_fast = tf;
    @(posedge clk);
    model_update(wr, a, d, ts, tf);
    @(negedge clk);
    expect4({cur_req, " rdata"}, bus_rdata, model_read(a));
    expect4({cur_req, " wake"}, {3'b0, wake_pulse}, {3'b0, m_wake});
    expect4({cur_req, " nmi"}, {3'b0, nmi_pulse}, {3'b0, m_nmi});
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] d);
    cycle(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd_check(input string tag, input logic [4:0] a, input logic [3:0] exp);
    cycle(1'b0, a, 4'h0, 1'b0, 1'b0);
    expect4(tag, bus_rdata, exp);
  endtask

  task automatic write_long(input logic [31:0] v);
    for (int k = 0; k < 8; k++) wr(5'(8 + k), v[k*4 +: 4]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] ra;
    m_s = 0; m_sc = 0; m_lc = 0; m_svc = 0; m_l = 0; m_wake = 0; m_nmi = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cur_req = "R1";
    expect4("R1 wake after reset", {3'b0, wake_pulse}, 4'h0);
    expect4("R1 nmi after reset", {3'b0, nmi_pulse}, 4'h0);
    for (int a = 0; a < 16; a++) rd_check("R1 reset readback", 5'(a), 4'h0);

    // R2: halted, then running
    cur_req = "R2";
    wr(5'd0, 4'h5);
    repeat (3) cycle(1'b0, 5'd0, 4'h0, 1'b1, 1'b1);
    rd_check("R2 halted short", 5'd0, 4'h5);
    rd_check("R3 halted long", 5'd8, 4'h0);
    wr(5'd2, 4'h1);
    cycle(1'b0, 5'd0, 4'h0, 1'b1, 1'b0);
    expect4("R2 one step", bus_rdata, 4'h4);

    // R3/R4: long counter nibble access and step
    cur_req = "R4";
    write_long(32'h1234_5678);
    for (int k = 0; k < 8; k++) rd_check("R4 nibble readback", 5'(8 + k), 4'(8 - k));
    cur_req = "R3";
    cycle(1'b0, 5'd8, 4'h0, 1'b0, 1'b1);
    expect4("R3 long step", bus_rdata, 4'h7);
    cur_req = "R4";
    wr(5'd11, 4'hA);
    rd_check("R4 neighbour kept", 5'd10, 4'h6);
    rd_check("R4 nibble replaced", 5'd11, 4'hA);
    rd_check("R4 neighbour kept hi", 5'd12, 4'h4);

    // R5: write beats tick
    cur_req = "R5";
    wr(5'd1, 4'h6);
    cycle(1'b1, 5'd0, 4'h0, 1'b1, 1'b0);
    cycle(1'b1, 5'd0, 4'h9, 1'b1, 1'b0);
    expect4("R5 short write wins", bus_rdata, 4'h9);
    expect4("R5 no pulse", {2'b0, wake_pulse, nmi_pulse}, 4'h0);
    cycle(1'b1, 5'd8, 4'h3, 1'b0, 1'b1);
    expect4("R5 long write wins", bus_rdata, 4'h3);
    rd_check("R5 long not decremented", 5'd9, 4'h7);

    // R6: wake only
    cur_req = "R6";
    wr(5'd1, 4'h4); wr(5'd0, 4'h0);
    cycle(1'b0, 5'd1, 4'h0, 1'b1, 1'b0);
    expect4("R6 wake pulse", {2'b0, wake_pulse, nmi_pulse}, 4'h2);
    expect4("R6 ctl flag", bus_rdata, 4'hC);
    cycle(1'b0, 5'd3, 4'h0, 1'b0, 1'b0);
    expect4("R6 pulse one cycle", {2'b0, wake_pulse, nmi_pulse}, 4'h0);
    expect4("R6 global flag", bus_rdata, 4'h4);

    // R7: NMI only, long timer
    cur_req = "R7";
    wr(5'd3, 4'h0);
    write_long(32'h0);
    wr(5'd2, 4'h3);
    cycle(1'b0, 5'd2, 4'h0, 1'b0, 1'b1);
    expect4("R7 nmi pulse", {2'b0, wake_pulse, nmi_pulse}, 4'h1);
    expect4("R7 long ctl flag", bus_rdata, 4'hB);
    rd_check("R7 global flag", 5'd3, 4'h4);
    rd_check("R7 long all ones", 5'd15, 4'hF);

    // R8: wrap with no enable
    cur_req = "R8";
    wr(5'd3, 4'h0); wr(5'd1, 4'h0); wr(5'd0, 4'h0);
    cycle(1'b0, 5'd0, 4'h0, 1'b1, 1'b0);
    expect4("R8 wrapped silently", bus_rdata, 4'hF);
    expect4("R8 no pulse", {2'b0, wake_pulse, nmi_pulse}, 4'h0);
    rd_check("R8 no ctl flag", 5'd1, 4'h0);
    rd_check("R8 no global flag", 5'd3, 4'h0);

    // R9: set beats clear, both timers together
    cur_req = "R9";
    wr(5'd1, 4'h6); wr(5'd0, 4'h0); write_long(32'h0); wr(5'd2, 4'h5);
    cycle(1'b1, 5'd3, 4'h0, 1'b1, 1'b1);
    expect4("R9 global set beats clear", bus_rdata, 4'h4);
    expect4("R9 both pulses", {2'b0, wake_pulse, nmi_pulse}, 4'h3);
    wr(5'd0, 4'h0);
    cycle(1'b1, 5'd1, 4'h6, 1'b1, 1'b0);
    expect4("R9 ctl set beats clear", bus_rdata, 4'hE);
    repeat (4) cycle(1'b0, 5'd1, 4'h0, 1'b0, 1'b0);
    expect4("R9 flag stays", bus_rdata, 4'hE);
    wr(5'd1, 4'h6);
    expect4("R9 software clear", bus_rdata, 4'h6);

    // R10: unmapped offsets
    cur_req = "R10";
    wr(5'd5, 4'hF); wr(5'd20, 4'hF);
    rd_check("R10 unmapped 5", 5'd5, 4'h0);
    rd_check("R10 unmapped 20", 5'd20, 4'h0);
    rd_check("R10 short ctl untouched", 5'd1, 4'h6);

    // Random mix, zero-heavy data to make wraps and collisions common
    cur_req = "R5 random";
    for (int i = 0; i < 4000; i++) begin
      int pick;
      pick = int'($urandom_range(0, 15));
      if (pick < 4)       ra = 5'(pick);
      else if (pick < 13) ra = 5'(8 + (pick - 4) % 8);
      else                ra = 5'($urandom_range(0, 31));
      cycle(($urandom_range(0, 9) < 3), ra,
            ($urandom_range(0, 1) == 0) ? 4'h0 : 4'($urandom_range(0, 15)),
            ($urandom_range(0, 9) < 3), ($urandom_range(0, 9) < 4));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule